// File: doc/BRIEF.md
# RTC Interrupt and Alarm Unit

This block sits beside a real-time clock's timekeeping core and turns the core's change events into a single level interrupt. It receives one-cycle pulses when the seconds, minutes, hours or day counter changes value, plus a pulse when a load into the latched time registers has finished. It also receives the current time of day. Each counter event, and an alarm event, is gated by its own enable bit and recorded in a sticky status register. The interrupt line stays high while any status bit is set. Software clears the bits by writing ones to them.

The alarm holds programmable hour, minute and second values. It compares them with the current time of day and ignores the day count. It raises its event once, on the cycle where the time first comes to equal the alarm. It does not raise it again on later cycles while the time still matches. The alarm registers and the status register share a small register bus with four word addresses.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset the status register reads 0, the interrupt output is low and the three alarm registers read 0.
- R2: A second, minute, hour or day event pulse sets status bit 0, 1, 2 or 3 respectively at the next clock edge, but only when the matching enable bit (`ctl_irq_en` bit 0, 1, 2 or 3) is 1. With the enable bit at 0 the event leaves the status register unchanged.
- R3: A load-complete pulse sets status bit 5 at the next clock edge regardless of every enable bit.
- R4: A bus write to address 3 clears every status bit whose data bit is 1 and leaves every status bit whose data bit is 0 unchanged.
- R5: When a set event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: The interrupt output is high exactly while at least one status bit is set.
- R7: The alarm second, minute and hour values sit at bus addresses 0, 1 and 2. They are 6, 6 and 5 bits wide. A write keeps only those low bits, and reads return them with the unused upper bits as 0.
- R8: When the alarm enable (`ctl_irq_en` bit 4) is 1, status bit 4 is set at the clock edge following the first cycle in which the time-of-day hour, minute and second all equal the alarm values. A difference in any one field prevents the match.
- R9: While the time keeps matching the alarm, the alarm sets status bit 4 no more than once. After software clears it, it stays clear until the time leaves the alarm value and returns to it.
- R10: A match that already holds when reset is released does not count as a first match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_sec | input | 1 | Seconds counter changed (one-cycle pulse) |
| evt_min | input | 1 | Minutes counter changed |
| evt_hour | input | 1 | Hours counter changed |
| evt_day | input | 1 | Day counter changed |
| evt_load_done | input | 1 | Load into latched registers complete |
| tod_sec | input | 6 | Current seconds |
| tod_min | input | 6 | Current minutes |
| tod_hour | input | 5 | Current hours |
| ctl_irq_en | input | 5 | Enables: bit0 second, bit1 minute, bit2 hour, bit3 day, bit4 alarm |
| reg_wr | input | 1 | Bus write strobe |
| reg_addr | input | 2 | Word address: 0 alarm sec, 1 alarm min, 2 alarm hour, 3 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
An event pulse or a clearing write presented in a cycle shows in the status register and on `irq` right after the next rising edge. A time-of-day change that completes an alarm match also lands at that edge, since the match edge-detector feeds the status register directly. Read data is combinational, so a read is due as soon as the address settles. The bench drives every input on the falling edge and checks one falling edge later, just after the edge that must have taken effect. Hold checks wait several further cycles with the inputs unchanged.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int SEC_W    = 6;
  localparam int MIN_W    = 6;
  localparam int HOUR_W   = 5;
  localparam int ADDR_W   = 2;
  localparam int NUM_STAT = 6;
  localparam int NUM_EN   = 5;

  localparam int ST_SEC  = 0;
  localparam int ST_MIN  = 1;
  localparam int ST_HOUR = 2;
  localparam int ST_DAY  = 3;
  localparam int ST_ALM  = 4;
  localparam int ST_LOAD = 5;

  localparam logic [ADDR_W-1:0] A_ALM_SEC  = 2'd0;
  localparam logic [ADDR_W-1:0] A_ALM_MIN  = 2'd1;
  localparam logic [ADDR_W-1:0] A_ALM_HOUR = 2'd2;
  localparam logic [ADDR_W-1:0] A_STATUS   = 2'd3;

  typedef struct packed {
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } tod_t;

  function automatic logic tod_equal(input tod_t a, input tod_t b);
    return (a.hour == b.hour) && (a.min == b.min) && (a.sec == b.sec);
  endfunction

  function automatic logic [NUM_STAT-1:0] status_next(
      input logic [NUM_STAT-1:0] cur,
      input logic [NUM_STAT-1:0] set,
      input logic [NUM_STAT-1:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output tod_t              alarm,
  output logic [DATA_W-1:0] rdata
);
  tod_t alarm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_ALM_SEC:  alarm_q.sec  <= wdata[SEC_W-1:0];
        A_ALM_MIN:  alarm_q.min  <= wdata[MIN_W-1:0];
        A_ALM_HOUR: alarm_q.hour <= wdata[HOUR_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_ALM_SEC:  rdata[SEC_W-1:0]  = alarm_q.sec;
      A_ALM_MIN:  rdata[MIN_W-1:0]  = alarm_q.min;
      A_ALM_HOUR: rdata[HOUR_W-1:0] = alarm_q.hour;
      default:    rdata = '0;
    endcase
  end

  assign alarm = alarm_q;

  // R7
  alarm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_ALM_HOUR) |=> (alarm.hour == $past(wdata[HOUR_W-1:0])));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  tod_t tod,
  input  tod_t alarm,
  output logic alarm_evt
);
  logic match_now;
  logic match_q;

  assign match_now = tod_equal(tod, alarm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b1;
    else        match_q <= match_now;
  end

  assign alarm_evt = match_now && !match_q;

  // R9
  alarm_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> !alarm_evt);
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
  import rtc_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_STAT-1:0] set_vec,
  input  logic [NUM_STAT-1:0] clr_vec,
  output logic [NUM_STAT-1:0] status
);
  logic [NUM_STAT-1:0] status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_next(status_q, set_vec, clr_vec);
  end

  assign status = status_q;

  for (genvar i = 0; i < NUM_STAT; i++) begin : g_bit_chk
    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> status[i]);
    // R4
    clear_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !status[i]);
    // R2
    hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_vec[i] && !set_vec[i]) |=> (status[i] == $past(status[i])));
  end
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_sec,
  input  logic              evt_min,
  input  logic              evt_hour,
  input  logic              evt_day,
  input  logic              evt_load_done,
  input  logic [SEC_W-1:0]  tod_sec,
  input  logic [MIN_W-1:0]  tod_min,
  input  logic [HOUR_W-1:0] tod_hour,
  input  logic [NUM_EN-1:0] ctl_irq_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  tod_t                tod_now;
  tod_t                alarm_val;
  logic [DATA_W-1:0]   alarm_rdata;
  logic                alarm_evt;
  logic                status_wr;
  logic [NUM_STAT-1:0] set_vec;
  logic [NUM_STAT-1:0] clr_vec;
  logic [NUM_STAT-1:0] status;

  assign tod_now = '{hour: tod_hour, min: tod_min, sec: tod_sec};

  rtc_alarm_regs #(.DATA_W(DATA_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .alarm (alarm_val),
    .rdata (alarm_rdata)
  );

  rtc_alarm_match u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .tod       (tod_now),
    .alarm     (alarm_val),
    .alarm_evt (alarm_evt)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[ST_SEC]  = evt_sec  && ctl_irq_en[ST_SEC];
    set_vec[ST_MIN]  = evt_min  && ctl_irq_en[ST_MIN];
    set_vec[ST_HOUR] = evt_hour && ctl_irq_en[ST_HOUR];
    set_vec[ST_DAY]  = evt_day  && ctl_irq_en[ST_DAY];
    set_vec[ST_ALM]  = alarm_evt && ctl_irq_en[ST_ALM];
    set_vec[ST_LOAD] = evt_load_done;
  end

  assign status_wr = reg_wr && (reg_addr == A_STATUS);
  assign clr_vec   = status_wr ? reg_wdata[NUM_STAT-1:0] : '0;

  rtc_irq_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .status  (status)
  );

  always_comb begin
    if (reg_addr == A_STATUS) begin
      reg_rdata                 = '0;
      reg_rdata[NUM_STAT-1:0]   = status;
    end else begin
      reg_rdata = alarm_rdata;
    end
  end

  assign irq = |status;

  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !status_wr) |=> irq);
  // R3
  load_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_load_done |=> irq);
endmodule

// File: tb/tb_rtc_irq_unit.sv
`timescale 1ns/1ps
module tb_rtc_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_sec = 0, evt_min = 0, evt_hour = 0, evt_day = 0, evt_load_done = 0;
  logic [5:0] tod_sec = 0, tod_min = 0;
  logic [4:0] tod_hour = 0;
  logic [4:0] ctl_irq_en = 5'b10000;
  logic       reg_wr = 0;
  logic [1:0] reg_addr = 2'd3;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rtc_irq_unit dut (
    .clk(clk), .rst_n(rst_n),
    .evt_sec(evt_sec), .evt_min(evt_min), .evt_hour(evt_hour), .evt_day(evt_day),
    .evt_load_done(evt_load_done),
    .tod_sec(tod_sec), .tod_min(tod_min), .tod_hour(tod_hour),
    .ctl_irq_en(ctl_irq_en),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // vector: events {load,day,hour,min,sec}, counter enables {day,hour,min,sec},
  // clearing write data, expected status after the edge
  typedef struct packed {
    logic [4:0] ev;
    logic [3:0] en;
    logic [5:0] clr;
    logic [5:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{5'b00001, 4'b1111, 6'b000000, 6'b000001},
    '{5'b00010, 4'b0000, 6'b000000, 6'b000001},
    '{5'b00010, 4'b0010, 6'b000000, 6'b000011},
    '{5'b01100, 4'b1100, 6'b000000, 6'b001111},
    '{5'b00000, 4'b0000, 6'b000001, 6'b001110},
    '{5'b00000, 4'b0000, 6'b000000, 6'b001110},
    '{5'b10000, 4'b0000, 6'b000000, 6'b101110},
    '{5'b00001, 4'b0001, 6'b000001, 6'b101111},
    '{5'b00000, 4'b0000, 6'b111111, 6'b000000},
    '{5'b01000, 4'b0111, 6'b000000, 6'b000000},
    '{5'b01111, 4'b1111, 6'b000000, 6'b001111},
    '{5'b00000, 4'b0000, 6'b001010, 6'b000101},
    '{5'b00000, 4'b0000, 6'b000101, 6'b000000}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic check_status(input string req, input logic [5:0] exp);
    logic [7:0] d;
    rd(2'd3, d);
    check(req, d, {2'b00, exp});
    check({req, " irq"}, {7'd0, irq}, {7'd0, exp != 0});
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check_status("R1", 6'h00);
    rd(2'd0, d); check("R1 alarm sec", d, 8'h00);
    rd(2'd1, d); check("R1 alarm min", d, 8'h00);
    rd(2'd2, d); check("R1 alarm hour", d, 8'h00);
    // R10 time equals reset alarm value with alarm enabled: no event
    repeat (4) @(negedge clk);
    check_status("R10", 6'h00);

    // R2 R3 R4 R5 R6 table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {evt_load_done, evt_day, evt_hour, evt_min, evt_sec} = VECS[i].ev;
      ctl_irq_en[3:0] = VECS[i].en;
      reg_wr = 1; reg_addr = 2'd3; reg_wdata = {2'b00, VECS[i].clr};
      @(negedge clk);
      {evt_load_done, evt_day, evt_hour, evt_min, evt_sec} = '0;
      reg_wr = 0; reg_wdata = 0;
      check_status($sformatf("R2/R3/R4/R5/R6 vec %0d", i), VECS[i].exp);
    end
    ctl_irq_en[3:0] = 4'b0000;

    // R7 field widths and readback
    wr(2'd0, 8'hFF); rd(2'd0, d); check("R7 sec width", d, 8'h3F);
    wr(2'd2, 8'hFF); rd(2'd2, d); check("R7 hour width", d, 8'h1F);
    wr(2'd1, 8'h2A); rd(2'd1, d); check("R7 min readback", d, 8'h2A);
    check_status("R7 status untouched", 6'h00);

    // R8 alarm 10:20:30
    wr(2'd0, 8'd30); wr(2'd1, 8'd20); wr(2'd2, 8'd10);
    @(negedge clk); tod_hour = 10; tod_min = 20; tod_sec = 29;
    @(negedge clk); check_status("R8 no match", 6'h00);
    tod_sec = 30;
    @(negedge clk); check_status("R8 match", 6'h10);
    // R9 clear while still matching: no refire
    wr(2'd3, 8'h10);
    check_status("R9 cleared", 6'h00);
    repeat (4) @(negedge clk);
    check_status("R9 held match", 6'h00);
    // R8 hour differs only
    tod_hour = 11;
    @(negedge clk); check_status("R8 hour mismatch", 6'h00);
    // R8 alarm disabled at match
    ctl_irq_en[4] = 0; tod_hour = 10;
    @(negedge clk); check_status("R8 disabled", 6'h00);
    ctl_irq_en[4] = 1;
    repeat (2) @(negedge clk); check_status("R9 enable during match", 6'h00);
    // R9 leave and return refires
    tod_sec = 31;
    @(negedge clk); tod_sec = 30;
    @(negedge clk); check_status("R9 return", 6'h10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule